// File: doc/BRIEF.md
# Receive Cell Event Interrupt Register

This block collects receive-side cell status events into one 8-bit sticky interrupt register. Seven live status lines come in from the cell delineation and header-check logic, already synchronous to the block clock. Each line is compared with a registered copy of itself from the previous clock. A qualifying transition latches a flag, provided the matching bit of a separate enable register is set.

The delineation-loss line counts both rising and falling transitions. Every other line counts only a rising transition. Software reads the flag register through a simple strobe-based register port. The read data appears on the next clock, and the read clears every flag. A flag whose event lands in the same cycle as the clearing read is not lost. A single interrupt output is high while any flag is latched.

Flag bit map: 7 delineation loss, 6 header error detected, 5 reserved, 4 cell received, 3 idle cell, 2 non-matching cell, 1 non-zero flow-control field, 0 header error corrected.

Top module: `rx_event_irq`

## Requirements
- R1: After reset, all flags and all enable bits are 0, `irq` is 0, and `rdata` is 0.
- R2: For flag bits 6, 4, 3, 2, 1 and 0, a 0-to-1 change on the matching `status_i` bit sets the flag when that bit is enabled. A 1-to-0 change on these bits sets nothing.
- R3: Flag bit 7 is set by either a 0-to-1 or a 1-to-0 change on `status_i[7]` when it is enabled.
- R4: A transition on a line whose enable bit is 0 sets no flag.
- R5: A read strobe (`rd_en`=1) at address 0x2D places the flag byte on `rdata` one clock later and clears all flags on that same edge.
- R6: If a qualifying event occurs in the same cycle as a flag read, the read returns the value from before the event, and the event's flag is set afterwards.
- R7: Bit 5 is reserved. It reads 0 in the flag byte and in the enable byte, even when `status_i[5]` toggles or software writes it to 1.
- R8: `irq` is 1 while any flag is 1. Clearing an enable bit removes neither the flag nor `irq`.
- R9: The enable register sits at address 0x2C. A write strobe (`wr_en`=1) there loads `wdata`, and a read there returns the stored value one clock later without clearing anything.
- R10: A flag stays set until a flag read, even after its status line returns to its old level.
- R11: A read at any other address returns 0 and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | 8 | Live status lines, using the flag bit map; bit 5 is unused |
| rd_en | input | 1 | Read strobe, one cycle |
| wr_en | input | 1 | Write strobe, one cycle |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Combined interrupt, high while any flag is set |

## Verification
A stale previous-status copy shows up as a phantom or missing flag in the very next flag read. It also shows up on `irq` one clock after the offending status change. A clear that reaches the wrong bits, or a read that captures after the update, returns a wrong byte on the read that follows. If a same-cycle event has been lost, the next read returns 0 where the event's flag should be. Each of these faults shows at most two clocks after its cause.

// File: rtl/rxint_pkg.sv
package rxint_pkg;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned ADDR_W = 8;
    localparam logic [ADDR_W-1:0] FLAG_ADDR = 8'h2D;
    localparam logic [ADDR_W-1:0] ENA_ADDR  = 8'h2C;
    // bits that react to both transition directions
    localparam logic [REG_W-1:0] DUAL_MASK = 8'h80;
    // bits that carry an event source (bit 5 reserved)
    localparam logic [REG_W-1:0] LIVE_MASK = 8'hDF;
endpackage

// File: rtl/rxint_edge.sv
module rxint_edge #(
    parameter bit DUAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic st,
    output logic hit
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= st;
    end

    generate
        if (DUAL) begin : g_both
            assign hit = st ^ prev_q;
        end else begin : g_rise
            assign hit = st & ~prev_q;
        end
    endgenerate
endmodule

// File: rtl/rxint_flag.sv
module rxint_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // a set in the clearing cycle wins, so no event is dropped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= (q & ~clr) | set;
    end
endmodule

// File: rtl/rxint_regif.sv
module rxint_regif
    import rxint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [REG_W-1:0]  flags,
    output logic [REG_W-1:0]  ena,
    output logic              clr_flags,
    output logic [REG_W-1:0]  rdata
);
    logic [REG_W-1:0] rd_next;

    assign clr_flags = rd_en && (addr == FLAG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           ena <= '0;
        else if (wr_en && (addr == ENA_ADDR)) ena <= wdata & LIVE_MASK;
    end

    always_comb begin
        rd_next = '0;
        if (rd_en) begin
            unique case (addr)
                FLAG_ADDR: rd_next = flags;
                ENA_ADDR:  rd_next = ena;
                default:   rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end
endmodule

// File: rtl/rx_event_irq.sv
module rx_event_irq
    import rxint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  status_i,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              irq
);
    logic [REG_W-1:0] hit;
    logic [REG_W-1:0] ena;
    logic [REG_W-1:0] flags;
    logic             rd_flags;

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        rxint_edge #(.DUAL(DUAL_MASK[i])) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .st   (status_i[i]),
            .hit  (hit[i])
        );
        rxint_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (hit[i] & ena[i]),
            .clr  (rd_flags),
            .q    (flags[i])
        );
    end

    rxint_regif u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .flags    (flags),
        .ena      (ena),
        .clr_flags(rd_flags),
        .rdata    (rdata)
    );

    assign irq = |flags;
endmodule

// File: rtl/rxint_chk.sv
module rxint_chk
    import rxint_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] status,
    input logic [REG_W-1:0] hit,
    input logic [REG_W-1:0] ena,
    input logic [REG_W-1:0] flags,
    input logic             rd_hit,
    input logic [REG_W-1:0] rdata,
    input logic             irq
);
    p_rise_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit & ~DUAL_MASK & ~status) == '0);

    p_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~$past(flags) & ~$past(ena)) == '0);

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_hit) |-> (flags & ~$past(hit & ena)) == '0);

    p_old_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_hit) |-> rdata == $past(flags));

    p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[5] && !rdata[5] && !ena[5]);

    p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_hit) && ($past(hit & ena) == '0)) |-> !irq);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_hit) |-> ($past(flags) & ~flags) == '0);
endmodule

bind rx_event_irq rxint_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .status(status_i),
    .hit   (hit),
    .ena   (ena),
    .flags (flags),
    .rd_hit(rd_flags),
    .rdata (rdata),
    .irq   (irq)
);

// File: tb/tb_rx_event_irq.sv
module tb_rx_event_irq;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] status_i;
    logic       rd_en;
    logic       wr_en;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #5 clk = ~clk;

    rx_event_irq dut (
        .clk(clk), .rst_n(rst_n), .status_i(status_i), .rd_en(rd_en),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_status(input logic [7:0] v);
        status_i = v;
        tick();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    // driver: pushes the expected read data, then issues the read strobe
    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_en = 1'b1; addr = a;
        tick();
        rd_en = 1'b0;
    endtask

    // monitor: rdata is valid the cycle after the strobe
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard underflow", rdata, 8'h00);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rdata == e, t, rdata, e);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=00 expected=01");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; status_i = '0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(irq == 1'b0, "R1 irq after reset", {7'd0, irq}, 8'h00);
        chk(rdata == 8'h00, "R1 rdata after reset", rdata, 8'h00);
        rd(8'h2D, 8'h00, "R1 flags after reset");
        rd(8'h2C, 8'h00, "R1 enables after reset");

        wr(8'h2C, 8'hFF);
        rd(8'h2C, 8'hDF, "R9/R7 enable readback with reserved bit");
        rd(8'h2C, 8'hDF, "R9 enable read does not clear");

        set_status(8'h5F);
        chk(irq == 1'b1, "R8 irq on latched flags", {7'd0, irq}, 8'h01);
        rd(8'h2D, 8'h5F, "R2 rising edges latched");
        chk(irq == 1'b0, "R5 irq after clearing read", {7'd0, irq}, 8'h00);
        rd(8'h2D, 8'h00, "R5 flags cleared by read");

        set_status(8'h00);
        chk(irq == 1'b0, "R2 falling edges give no irq", {7'd0, irq}, 8'h00);
        rd(8'h2D, 8'h00, "R2 falling edges ignored");

        set_status(8'h80);
        rd(8'h2D, 8'h80, "R3 delineation rise");
        set_status(8'h00);
        rd(8'h2D, 8'h80, "R3 delineation fall");

        set_status(8'h20);
        chk(irq == 1'b0, "R7 reserved line gives no irq", {7'd0, irq}, 8'h00);
        rd(8'h2D, 8'h00, "R7 reserved line ignored");
        set_status(8'h00);

        wr(8'h2C, 8'h00);
        set_status(8'hC1);
        chk(irq == 1'b0, "R4 disabled no irq", {7'd0, irq}, 8'h00);
        rd(8'h2D, 8'h00, "R4 disabled no flags");
        set_status(8'h00);

        wr(8'h2C, 8'hFF);
        set_status(8'h02);
        set_status(8'h00);
        chk(irq == 1'b1, "R10 flag held after line returns", {7'd0, irq}, 8'h01);
        rd(8'h10, 8'h00, "R11 other address reads zero");
        chk(irq == 1'b1, "R11 other address does not clear", {7'd0, irq}, 8'h01);
        rd(8'h2D, 8'h02, "R10 sticky flag value");

        set_status(8'h01);
        wr(8'h2C, 8'h00);
        chk(irq == 1'b1, "R8 disabling keeps irq", {7'd0, irq}, 8'h01);
        rd(8'h2D, 8'h01, "R8 disabling keeps flag");
        chk(irq == 1'b0, "R8 irq drops after read", {7'd0, irq}, 8'h00);
        set_status(8'h00);

        wr(8'h2C, 8'hFF);
        set_status(8'h10);
        status_i = 8'h14;
        rd(8'h2D, 8'h10, "R6 read returns pre-event value");
        chk(irq == 1'b1, "R6 same-cycle event keeps irq", {7'd0, irq}, 8'h01);
        rd(8'h2D, 8'h04, "R6 same-cycle event kept");
        chk(irq == 1'b0, "R6 irq clear afterwards", {7'd0, irq}, 8'h00);

        repeat (2) tick();
        chk(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule